// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block is one channel of a compare-based timer output. It watches a free-running count supplied by a shared counter. In each counter tick where the count equals a programmed compare value, it raises a compare event. The event drives a selectable action on an output pin and latches a sticky flag. Software can also request the same pin action directly through a force strobe. A forced action moves the pin but never marks a compare event. The flag raises an interrupt request while the per-channel enable is set.

A timer with several output channels places one instance per channel. All instances share the count and the tick strobe. Register decoding sits outside the block: the force and flag-clear inputs are one-cycle strobes produced by a write of 1, and they read back as 0. Pin actions take effect on the clock edge after the cycle in which the event or force is presented.

Top module: `ocmp_pin_unit`

## Requirements
- R1: During and after reset the pin is high, the flag is 0 and the interrupt request is 0.
- R2: A compare event occurs in a cycle where `cnt_tick` is 1 and `count` equals `cmp_val`. The flag is set at the next clock edge. While the count is held equal with `cnt_tick` at 0, no event occurs.
- R3: Mode 3'b000 leaves the pin unchanged on compare events and on force strobes. The flag still sets on a compare event.
- R4: Mode 3'b001 inverts the pin once per action.
- R5: Mode 3'b010 drives the pin low on an action.
- R6: Mode 3'b011 drives the pin high on an action.
- R7: Any mode with bit 2 set drives the pin low on an action. The pin returns high at the edge that ends the next cycle with `cnt_tick` at 1, so the low pulse lasts one counter tick.
- R8: A force strobe applies the programmed pin action at the next edge and does not set the flag. Each cycle with `force_strb` at 1 is one action, and the action needs no tick.
- R9: A `flag_clr` strobe clears the flag at the next edge. When a compare event occurs in the same cycle as the clear, the flag stays set.
- R10: `irq` is 1 exactly when the flag and `irq_en` are both 1. The default build adds no register delay.
- R11: A compare event and a force strobe in the same cycle produce a single pin action and set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Strobe: counter advances after this cycle; count is sampled for a match |
| count | input | CNT_W | Current counter value |
| cmp_val | input | CNT_W | Programmed compare value |
| mode | input | 3 | Pin action select |
| force_strb | input | 1 | Software force strobe |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Interrupt enable |
| pin_out | output | 1 | Compare output pin |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
A held equal count with no tick is run against a single tick. This tells tick-qualified matching apart from level matching. Every mode is driven both by matches and by forces, so pin actions can be separated from flag setting. Pulse mode runs under sparse and dense ticks, which checks that the pulse width follows ticks and not clocks. Coincident pairs are also driven: match with clear, and match with force. A long pseudo-random phase then mixes mode changes, forces, clears and enable changes, and a behavioural model is compared with the outputs on every clock.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
   typedef enum logic [2:0] {
      ACT_NONE  = 3'd0,
      ACT_TOG   = 3'd1,
      ACT_LOW   = 3'd2,
      ACT_HIGH  = 3'd3,
      ACT_PULSE = 3'd4
   } pin_act_e;

   localparam int MODE_W = 3;

   function automatic pin_act_e decode_mode(input logic [MODE_W-1:0] m);
      if (m[2])               return ACT_PULSE;
      else if (m[1:0] == 2'd1) return ACT_TOG;
      else if (m[1:0] == 2'd2) return ACT_LOW;
      else if (m[1:0] == 2'd3) return ACT_HIGH;
      else                     return ACT_NONE;
   endfunction
endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
   parameter int CNT_W   = 32,
   parameter int SLICE_W = 8
) (
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             match_evt
);
   localparam int NSL   = (CNT_W + SLICE_W - 1) / SLICE_W;
   localparam int PAD_W = NSL * SLICE_W;

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 64) else $error("CNT_W out of range");
      assert (SLICE_W >= 1 && SLICE_W <= CNT_W) else $error("SLICE_W out of range");
   end

   logic [PAD_W-1:0] cnt_p, cmp_p;
   logic [NSL-1:0]   eq_sl;

   assign cnt_p = PAD_W'(count);
   assign cmp_p = PAD_W'(cmp_val);

   for (genvar gi = 0; gi < NSL; gi++) begin : g_slice
      assign eq_sl[gi] = (cnt_p[gi*SLICE_W +: SLICE_W] == cmp_p[gi*SLICE_W +: SLICE_W]);
   end

   assign match_evt = tick & (&eq_sl);
endmodule

// File: rtl/ocmp_pin_ctl.sv
module ocmp_pin_ctl
   import ocmp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              act,
   input  logic [MODE_W-1:0] mode,
   output logic              pin
);
   pin_act_e kind;
   logic     act_eff;
   logic     pin_q, pulse_q;

   assign kind    = decode_mode(mode);
   assign act_eff = act && (kind != ACT_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q   <= 1'b1;
         pulse_q <= 1'b0;
      end else if (act_eff) begin
         unique case (kind)
            ACT_TOG:   begin pin_q <= ~pin_q; pulse_q <= 1'b0; end
            ACT_LOW:   begin pin_q <= 1'b0;   pulse_q <= 1'b0; end
            ACT_HIGH:  begin pin_q <= 1'b1;   pulse_q <= 1'b0; end
            ACT_PULSE: begin pin_q <= 1'b0;   pulse_q <= 1'b1; end
            default:   ;
         endcase
      end else if (pulse_q && tick) begin
         pin_q   <= 1'b1;
         pulse_q <= 1'b0;
      end
   end

   assign pin = pin_q;

   a_r3_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (act && mode == 3'b000 && !pulse_q) |=> $stable(pin));
   a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (act && mode == 3'b001) |=> (pin != $past(pin)));
   a_r5_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
      (act && mode == 3'b010) |=> !pin);
   a_r6_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
      (act && mode == 3'b011) |=> pin);
   a_r7_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
      (act && mode[2]) |=> (!pin && pulse_q));
   a_r7_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && tick && !act) |=> pin);
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag #(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (set) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
   end

   assign flag = flag_q;

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag_q & irq_en;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = flag_q & irq_en;
      a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq) |-> (flag_q && irq_en));
   end

   a_r2_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/ocmp_pin_unit.sv
module ocmp_pin_unit
   import ocmp_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int SLICE_W = 8,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_tick,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [2:0]       mode,
   input  logic             force_strb,
   input  logic             flag_clr,
   input  logic             irq_en,
   output logic             pin_out,
   output logic             cmp_flag,
   output logic             irq
);
   logic match_evt;

   ocmp_match #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_match (
      .tick(cnt_tick), .count(count), .cmp_val(cmp_val), .match_evt(match_evt));

   ocmp_pin_ctl u_pin (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
      .act(match_evt | force_strb), .mode(mode), .pin(pin_out));

   ocmp_flag #(.REG_IRQ(REG_IRQ)) u_flag (
      .clk(clk), .rst_n(rst_n), .set(match_evt), .clr(flag_clr),
      .irq_en(irq_en), .flag(cmp_flag), .irq(irq));

   a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (force_strb && !cnt_tick && !cmp_flag) |=> !cmp_flag);
   a_r11_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (force_strb && match_evt && mode == 3'b001) |=> (pin_out != $past(pin_out)));
   a_r2_no_tick_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_tick && !cmp_flag) |=> !cmp_flag);
endmodule

// File: tb/ocmp_pin_unit_tb.sv
module ocmp_pin_unit_tb;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_tick = 1'b0;
   logic [W-1:0] count = '0;
   logic [W-1:0] cmp_val = '0;
   logic [2:0]   mode = 3'b000;
   logic         force_strb = 1'b0;
   logic         flag_clr = 1'b0;
   logic         irq_en = 1'b0;
   logic         pin_out, cmp_flag, irq;

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #10 clk = ~clk;

   ocmp_pin_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .count(count),
      .cmp_val(cmp_val), .mode(mode), .force_strb(force_strb),
      .flag_clr(flag_clr), .irq_en(irq_en), .pin_out(pin_out),
      .cmp_flag(cmp_flag), .irq(irq));

   // behavioural reference
   logic m_pin = 1'b1, m_flag = 1'b0, m_pulse = 1'b0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pin <= 1'b1; m_flag <= 1'b0; m_pulse <= 1'b0;
      end else begin
         bit ev, act;
         ev  = cnt_tick && (count == cmp_val);
         act = (ev || force_strb) && (mode != 3'b000);
         if (act) begin
            if (mode >= 3'd4) begin m_pin <= 1'b0; m_pulse <= 1'b1; end
            else begin
               m_pulse <= 1'b0;
               if (mode == 3'd1) m_pin <= ~m_pin;
               else              m_pin <= (mode == 3'd3);
            end
         end else if (m_pulse && cnt_tick) begin
            m_pin <= 1'b1; m_pulse <= 1'b0;
         end
         if (ev) m_flag <= 1'b1;
         else if (flag_clr) m_flag <= 1'b0;
      end
   end

   task automatic chk(string req, string what, logic act_v, logic exp_v);
      n_chk++;
      if (act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act_v, exp_v, $time);
      end
   endtask

   always @(negedge clk) if (!done) begin
      chk(cur_req, "pin", pin_out, m_pin);
      chk(cur_req, "flag", cmp_flag, m_flag);
      chk(cur_req, "irq", irq, m_flag & irq_en);
   end

   // drive one cycle, then advance count if ticked
   task automatic step(bit t, bit f, bit c);
      cnt_tick = t; force_strb = f; flag_clr = c;
      @(negedge clk);
      if (t) count = count + 1;
      cnt_tick = 1'b0; force_strb = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] seed;
      seed = 32'h1234_5678;
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("R1", "pin in reset", pin_out, 1'b1);
      chk("R1", "flag in reset", cmp_flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "irq after reset", irq, 1'b0);

      // R2: held equal count without tick, then one tick
      cur_req = "R2"; irq_en = 1'b1; mode = 3'b000;
      count = 32'd10; cmp_val = 32'd10;
      repeat (4) step(1'b0, 1'b0, 1'b0);
      chk("R2", "no flag without tick", cmp_flag, 1'b0);
      step(1'b1, 1'b0, 1'b0);
      chk("R2", "flag after tick match", cmp_flag, 1'b1);
      repeat (3) step(1'b1, 1'b0, 1'b0);

      // R9: clear, then clear coincident with match
      cur_req = "R9";
      step(1'b0, 1'b0, 1'b1);
      chk("R9", "flag cleared", cmp_flag, 1'b0);
      count = 32'd20; cmp_val = 32'd20;
      step(1'b1, 1'b0, 1'b1);
      chk("R9", "match beats clear", cmp_flag, 1'b1);
      step(1'b0, 1'b0, 1'b1);

      // R10: enable gating
      cur_req = "R10";
      count = 32'd30; cmp_val = 32'd30; irq_en = 1'b0;
      step(1'b1, 1'b0, 1'b0);
      chk("R10", "irq masked", irq, 1'b0);
      irq_en = 1'b1; #1;
      chk("R10", "irq unmasked", irq, 1'b1);
      step(1'b0, 1'b0, 1'b1);

      // R3: off mode ignores match and force
      cur_req = "R3"; mode = 3'b000; count = 32'd40; cmp_val = 32'd41;
      repeat (3) step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      chk("R3", "pin unchanged", pin_out, 1'b1);
      step(1'b0, 1'b0, 1'b1);

      // R4: toggle via matches
      cur_req = "R4"; mode = 3'b001;
      for (int k = 0; k < 3; k++) begin
         count = 32'd50; cmp_val = 32'd51;
         repeat (3) step(1'b1, 1'b0, 1'b0);
      end
      chk("R4", "pin after three toggles", pin_out, 1'b0);

      // R5 / R6
      cur_req = "R6"; mode = 3'b011; count = 32'd60; cmp_val = 32'd61;
      repeat (3) step(1'b1, 1'b0, 1'b0);
      chk("R6", "pin high", pin_out, 1'b1);
      cur_req = "R5"; mode = 3'b010; count = 32'd60;
      repeat (3) step(1'b1, 1'b0, 1'b0);
      chk("R5", "pin low", pin_out, 1'b0);

      // R8: force without flag
      cur_req = "R8"; step(1'b0, 1'b0, 1'b1);
      mode = 3'b011;
      step(1'b0, 1'b1, 1'b0);
      chk("R8", "forced high", pin_out, 1'b1);
      chk("R8", "force leaves flag", cmp_flag, 1'b0);
      mode = 3'b001;
      step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0);
      chk("R8", "two forced toggles", pin_out, 1'b1);

      // R7: pulse under sparse ticks
      cur_req = "R7"; mode = 3'b110; count = 32'd70; cmp_val = 32'd70;
      step(1'b1, 1'b0, 1'b0);
      chk("R7", "pulse low", pin_out, 1'b0);
      repeat (3) step(1'b0, 1'b0, 1'b0);
      chk("R7", "still low without tick", pin_out, 1'b0);
      step(1'b1, 1'b0, 1'b0);
      chk("R7", "pulse ended at tick", pin_out, 1'b1);
      mode = 3'b100;
      step(1'b0, 1'b1, 1'b0);
      chk("R7", "forced pulse low", pin_out, 1'b0);
      step(1'b1, 1'b0, 1'b0);
      chk("R7", "forced pulse ended", pin_out, 1'b1);

      // R11: match and force together
      cur_req = "R11"; step(1'b0, 1'b0, 1'b1);
      mode = 3'b001; count = 32'd80; cmp_val = 32'd80;
      step(1'b1, 1'b1, 1'b0);
      chk("R11", "single toggle", pin_out, 1'b0);
      chk("R11", "flag set", cmp_flag, 1'b1);

      // mixed pseudo-random phase
      cur_req = "R7";
      for (int i = 0; i < 1200; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         if (i % 40 == 0) begin
            mode = seed[18:16];
            cmp_val = count + {29'd0, seed[22:20]};
         end
         if (i % 57 == 0) irq_en = seed[25];
         step(seed[27] | seed[28], seed[30:29] == 2'b11 && seed[10], seed[31] && seed[11:9] == 3'b000);
      end

      finish_run();
   end
endmodule